// File: doc/BRIEF.md
# Byte-Stream Transaction Request Executor

This block sits on the device side of a serial register-access link. It receives one transaction-layer packet at a time as a stream of unescaped bytes, with start and end flags. It decodes an 8-byte request header and runs single or address-incrementing word reads and writes on a simple memory-mapped master port. It then sends a response packet back as a byte stream with the same flags.

The header holds an opcode byte, a reserved byte, a 16-bit byte count sent most significant byte first, and a 32-bit address sent most significant byte first. Write data words follow the header with their least significant byte first. A write is answered with a 4-byte response header. A read is answered with the data words alone.

Write data is collected in a small buffer. No bus write starts until the whole packet has arrived, so a cut-short packet leaves the bus untouched.

Operation is one state machine:
- `S_IDLE` waits for a start-flagged byte.
- `S_HDR` collects the header.
- `S_WDATA` collects write data.
- `S_DROP` discards surplus bytes up to the end flag.
- `S_WR_BUS` runs one write per word.
- `S_RD_BUS` issues a read.
- `S_RD_WAIT` waits for read data.
- `S_RD_SEND` emits four data bytes.
- `S_RSP` emits the 4-byte response header.

Transitions:
- A start flag in any receive state restarts at `S_HDR`.
- An end flag before the packet is complete returns to `S_IDLE`.
- A complete packet dispatches to `S_WR_BUS`, `S_RD_BUS` or `S_RSP`.
- `S_WR_BUS` moves to `S_RSP` after its last word.
- `S_RD_BUS` → `S_RD_WAIT` → `S_RD_SEND` repeats per word, then returns to `S_IDLE`.
- `S_RSP` returns to `S_IDLE` after four bytes.

Top module: `bytestream_txn_exec`

## Requirements
- R1: A packet begins with a byte flagged `in_sop`. That byte is the opcode. Byte 1 is reserved, bytes 2..3 are the count (high byte first) and bytes 4..7 are the address (high byte first). Bytes seen in `S_IDLE` without `in_sop` are ignored.
- R2: Opcode 0x00 with count 4 makes exactly one bus write to the header address. Its data word is assembled from the 4 data bytes, with the first byte in bits 7:0.
- R3: Opcode 0x04 with a nonzero count that is a multiple of 4 and at most 4*MAX_WR_WORDS makes count/4 bus writes. The writes go in order, to address, address+4, and so on.
- R4: After the writes, the response is 4 bytes: opcode|0x80, 0x00, count[15:8], count[7:0]. `out_sop` is set on the first byte and `out_eop` on the last.
- R5: Opcode 0x10 with count 4 makes one bus read at the header address. The response is the 4 data bytes, bits 7:0 first, with no header, and with `out_sop` on the first byte and `out_eop` on the last.
- R6: Opcode 0x14 with a nonzero count that is a multiple of 4 makes count/4 reads at incrementing addresses. The data is streamed as one packet of count bytes.
- R7: Any other opcode (0x7F included), or a count that is not valid for its opcode, makes no bus access. It is answered with opcode|0x80, 0x00, 0x00, 0x00.
- R8: A command holds `bus_write`/`bus_read`, `bus_addr` and `bus_wdata` steady while `bus_waitreq` is high. Read data is taken only on `bus_rvalid` after the read is accepted. A read and a write are never asserted together.
- R9: A packet that ends before its header, or before its declared write data, is complete causes no bus access and no response.
- R10: A start-flagged byte inside a packet restarts header collection. Bytes after a complete request are discarded, and the request runs at the end flag.
- R11: `out_data`/`out_sop`/`out_eop` stay steady while `out_valid` is high and `out_ready` is low. `in_ready` is high after reset and low from a complete packet's end flag until its response is finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request byte valid |
| in_ready | output | 1 | Block accepts a request byte |
| in_data | input | 8 | Request byte |
| in_sop | input | 1 | Byte is first of packet |
| in_eop | input | 1 | Byte is last of packet |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Response byte taken |
| out_data | output | 8 | Response byte |
| out_sop | output | 1 | First response byte |
| out_eop | output | 1 | Last response byte |
| bus_addr | output | 32 | Master byte address |
| bus_wdata | output | 32 | Master write data |
| bus_write | output | 1 | Write command |
| bus_read | output | 1 | Read command |
| bus_waitreq | input | 1 | Slave holds the command |
| bus_rdata | input | 32 | Read data |
| bus_rvalid | input | 1 | Read data valid |

## Verification
The assertions assume a bus slave that returns exactly one `bus_rvalid` pulse per accepted read, never before the cycle after acceptance. They also assume a stream source that holds a byte until `in_ready` takes it. The bench's slave model raises `bus_rvalid` for one cycle, one cycle after it sees a read accepted. Its byte driver only presents a byte while `in_ready` is high. Stall patterns on `bus_waitreq` and `out_ready` are switched on and off so that the hold rules are exercised without breaking those assumptions.

// File: rtl/txn_exec_pkg.sv
package txn_exec_pkg;
    localparam logic [7:0] OP_WR     = 8'h00;
    localparam logic [7:0] OP_WR_SEQ = 8'h04;
    localparam logic [7:0] OP_RD     = 8'h10;
    localparam logic [7:0] OP_RD_SEQ = 8'h14;
    localparam logic [7:0] RSP_FLAG  = 8'h80;

    typedef enum logic [1:0] {K_REJ, K_WR, K_RD} kind_t;

    typedef enum logic [3:0] {
        S_IDLE, S_HDR, S_WDATA, S_DROP,
        S_WR_BUS, S_RD_BUS, S_RD_WAIT, S_RD_SEND, S_RSP
    } state_t;
endpackage

// File: rtl/txn_classify.sv
module txn_classify
    import txn_exec_pkg::*;
#(
    parameter int MAX_WR_WORDS = 4
) (
    input  logic [7:0]  op,
    input  logic [15:0] cnt,
    output kind_t       kind,
    output logic [15:0] nwords
);
    localparam logic [15:0] WR_LIMIT = 16'(MAX_WR_WORDS);

    logic aligned;

    always_comb begin
        nwords  = {2'b00, cnt[15:2]};
        aligned = (cnt[1:0] == 2'b00) && (cnt != 16'd0);
        case (op)
            OP_WR:     kind = (cnt == 16'd4) ? K_WR : K_REJ;
            OP_WR_SEQ: kind = (aligned && nwords <= WR_LIMIT) ? K_WR : K_REJ;
            OP_RD:     kind = (cnt == 16'd4) ? K_RD : K_REJ;
            OP_RD_SEQ: kind = aligned ? K_RD : K_REJ;
            default:   kind = K_REJ;
        endcase
    end
endmodule

// File: rtl/txn_wbuf.sv
module txn_wbuf #(
    parameter int WORDS = 4,
    localparam int BW   = $clog2(WORDS * 4),
    localparam int WIW  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [BW-1:0]  wr_idx,
    input  logic [7:0]     wr_byte,
    input  logic [WIW-1:0] rd_idx,
    output logic [31:0]    rd_word
);
    logic [7:0]  lane [WORDS*4];
    logic [31:0] word_arr [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) lane[wr_idx] <= wr_byte;
    end

    for (genvar gw = 0; gw < WORDS; gw++) begin : g_word
        assign word_arr[gw] = {lane[4*gw+3], lane[4*gw+2], lane[4*gw+1], lane[4*gw]};
    end

    assign rd_word = word_arr[rd_idx];
endmodule

// File: rtl/bytestream_txn_exec.sv
module bytestream_txn_exec
    import txn_exec_pkg::*;
#(
    parameter int MAX_WR_WORDS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_sop,
    input  logic        in_eop,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_sop,
    output logic        out_eop,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    output logic        bus_write,
    output logic        bus_read,
    input  logic        bus_waitreq,
    input  logic [31:0] bus_rdata,
    input  logic        bus_rvalid
);
    localparam int BW  = $clog2(MAX_WR_WORDS * 4);
    localparam int WIW = (MAX_WR_WORDS > 1) ? $clog2(MAX_WR_WORDS) : 1;

    state_t      state;
    kind_t       kind;
    logic [7:0]  hdr_op;
    logic [15:0] hdr_cnt;
    logic [31:0] hdr_addr;
    logic [15:0] bidx;
    logic [15:0] widx;
    logic [15:0] nwords;
    logic [1:0]  sub;
    logic [31:0] rd_word;
    logic [31:0] buf_word;
    logic [15:0] wr_count;
    logic        in_fire;
    logic        last_word;
    logic        wbuf_we;

    txn_classify #(.MAX_WR_WORDS(MAX_WR_WORDS)) u_cls (
        .op(hdr_op), .cnt(hdr_cnt), .kind(kind), .nwords(nwords)
    );

    assign in_fire   = in_valid && in_ready;
    assign last_word = (widx == nwords - 16'd1);
    assign wbuf_we   = in_fire && !in_sop && (state == S_WDATA);
    assign wr_count  = (kind == K_WR) ? hdr_cnt : 16'd0;

    txn_wbuf #(.WORDS(MAX_WR_WORDS)) u_wbuf (
        .clk(clk), .wr_en(wbuf_we), .wr_idx(bidx[BW-1:0]), .wr_byte(in_data),
        .rd_idx(widx[WIW-1:0]), .rd_word(buf_word)
    );

    function automatic state_t dispatch(input kind_t k);
        case (k)
            K_WR:    return S_WR_BUS;
            K_RD:    return S_RD_BUS;
            default: return S_RSP;
        endcase
    endfunction

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            hdr_op   <= '0;
            hdr_cnt  <= '0;
            hdr_addr <= '0;
            bidx     <= '0;
            widx     <= '0;
            sub      <= '0;
            rd_word  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (in_fire && in_sop) begin
                        hdr_op <= in_data;
                        bidx   <= 16'd1;
                        state  <= in_eop ? S_IDLE : S_HDR;
                    end
                end
                S_HDR, S_WDATA, S_DROP: begin
                    if (in_fire) begin
                        if (in_sop) begin
                            hdr_op <= in_data;
                            bidx   <= 16'd1;
                            state  <= in_eop ? S_IDLE : S_HDR;
                        end else if (state == S_HDR) begin
                            case (bidx[2:0])
                                3'd2: hdr_cnt[15:8] <= in_data;
                                3'd3: hdr_cnt[7:0]  <= in_data;
                                3'd4, 3'd5, 3'd6, 3'd7: hdr_addr <= {hdr_addr[23:0], in_data};
                                default: ;
                            endcase
                            if (bidx == 16'd7) begin
                                bidx <= '0;
                                widx <= '0;
                                sub  <= '0;
                                if (in_eop) state <= (kind == K_WR) ? S_IDLE : dispatch(kind);
                                else        state <= (kind == K_WR) ? S_WDATA : S_DROP;
                            end else begin
                                bidx <= bidx + 16'd1;
                                if (in_eop) state <= S_IDLE;
                            end
                        end else if (state == S_WDATA) begin
                            if (bidx == hdr_cnt - 16'd1) begin
                                state <= in_eop ? S_WR_BUS : S_DROP;
                            end else begin
                                bidx <= bidx + 16'd1;
                                if (in_eop) state <= S_IDLE;
                            end
                        end else if (in_eop) begin
                            state <= dispatch(kind);
                        end
                    end
                end
                S_WR_BUS: begin
                    if (!bus_waitreq) begin
                        if (last_word) begin
                            state <= S_RSP;
                            sub   <= '0;
                        end else begin
                            widx <= widx + 16'd1;
                        end
                    end
                end
                S_RD_BUS: if (!bus_waitreq) state <= S_RD_WAIT;
                S_RD_WAIT: begin
                    if (bus_rvalid) begin
                        rd_word <= bus_rdata;
                        sub     <= '0;
                        state   <= S_RD_SEND;
                    end
                end
                S_RD_SEND: begin
                    if (out_ready) begin
                        sub <= sub + 2'd1;
                        if (sub == 2'd3) begin
                            if (last_word) state <= S_IDLE;
                            else begin
                                widx  <= widx + 16'd1;
                                state <= S_RD_BUS;
                            end
                        end
                    end
                end
                S_RSP: begin
                    if (out_ready) begin
                        sub <= sub + 2'd1;
                        if (sub == 2'd3) state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = (state inside {S_IDLE, S_HDR, S_WDATA, S_DROP});
        bus_addr  = hdr_addr + 32'({widx, 2'b00});
        bus_wdata = buf_word;
        bus_write = 1'b0;
        bus_read  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        unique case (state)
            S_WR_BUS: bus_write = 1'b1;
            S_RD_BUS: bus_read  = 1'b1;
            S_RD_SEND: begin
                out_valid = 1'b1;
                out_data  = 8'(rd_word >> {sub, 3'b000});
                out_sop   = (widx == 16'd0) && (sub == 2'd0);
                out_eop   = last_word && (sub == 2'd3);
            end
            S_RSP: begin
                out_valid = 1'b1;
                case (sub)
                    2'd0: out_data = hdr_op | RSP_FLAG;
                    2'd1: out_data = 8'h00;
                    2'd2: out_data = wr_count[15:8];
                    default: out_data = wr_count[7:0];
                endcase
                out_sop = (sub == 2'd0);
                out_eop = (sub == 2'd3);
            end
            default: ;
        endcase
    end

    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write || bus_read) && bus_waitreq |=>
        (bus_write == $past(bus_write)) && (bus_read == $past(bus_read)) &&
        $stable(bus_addr) && $stable(bus_wdata));

    assert_cmd_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_write && bus_read));

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=>
        out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

    assert_busy_no_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write || bus_read || out_valid) |-> !in_ready);

    assert_wr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_write |-> (kind == K_WR) && (widx < nwords));

    assert_rej_no_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_REJ) && !in_ready |-> !(bus_write || bus_read));
endmodule

// File: tb/bytestream_txn_exec_test.sv
module bytestream_txn_exec_test;
    localparam int MAXW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        out_valid, out_sop, out_eop;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_write, bus_read;
    logic        bus_waitreq = 1'b0;
    logic [31:0] bus_rdata = 32'h0;
    logic        bus_rvalid = 1'b0;

    always #2 clk = ~clk;

    bytestream_txn_exec #(.MAX_WR_WORDS(MAXW)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_write(bus_write),
        .bus_read(bus_read), .bus_waitreq(bus_waitreq), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid)
    );

    int checks = 0, fails = 0, cyc = 0;
    logic [31:0] mem [64];
    logic [31:0] wa [0:1023], wd [0:1023];
    logic [7:0]  rb [0:4095];
    bit          rs [0:4095], re [0:4095];
    int wn = 0, rn = 0, rsn = 0;
    int hold_viol = 0, both_viol = 0, stall_viol = 0;
    bit stall_bus = 0, stall_out = 0;
    bit rd_pend = 0;
    logic [31:0] rd_a;
    bit prev_w = 0, prev_r = 0, ost_prev = 0;
    logic [31:0] prev_a, prev_d;
    logic [9:0]  ost_v;
    logic [7:0]  pkt [0:63];

    function automatic logic [31:0] pat(input int i);
        return 32'h5A00_0000 ^ (32'(i) * 32'h0103_0507);
    endfunction

    function automatic logic [31:0] wdat(input int t, input int k);
        return {8'(t) ^ 8'h7A, 8'(k), 8'h4A, 8'(t + k)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // bus slave and response monitor: sample at negedge
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_write && bus_read) both_viol++;
            if ((prev_w || prev_r) && !(bus_write == prev_w && bus_read == prev_r &&
                bus_addr == prev_a && (!prev_w || bus_wdata == prev_d))) hold_viol++;
            prev_w = bus_write && bus_waitreq;
            prev_r = bus_read && bus_waitreq;
            prev_a = bus_addr;
            prev_d = bus_wdata;
            if (bus_write && !bus_waitreq) begin
                wa[wn] = bus_addr; wd[wn] = bus_wdata;
                mem[bus_addr[7:2]] = bus_wdata;
                wn++;
            end
            if (bus_read && !bus_waitreq) begin
                rd_pend = 1; rd_a = bus_addr; rn++;
            end
            if (out_valid) begin
                if (ost_prev && ost_v != {out_data, out_sop, out_eop}) stall_viol++;
                if (out_ready) begin
                    rb[rsn] = out_data; rs[rsn] = out_sop; re[rsn] = out_eop; rsn++;
                end
                ost_prev = !out_ready;
                ost_v = {out_data, out_sop, out_eop};
            end else begin
                if (ost_prev) stall_viol++;
                ost_prev = 0;
            end
        end
    end

    // slave and sink drive just after the rising edge
    always @(posedge clk) begin
        cyc++;
        #1;
        bus_rvalid = 1'b0;
        if (rd_pend) begin
            bus_rvalid = 1'b1;
            bus_rdata  = mem[rd_a[7:2]];
            rd_pend    = 0;
        end
        bus_waitreq = stall_bus && (cyc % 3 != 0);
        out_ready   = !stall_out || (cyc % 4 == 1);
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic send_byte(input logic [7:0] d, input bit s, input bit e);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic set_hdr(input logic [7:0] op, input logic [15:0] cnt, input logic [31:0] addr);
        pkt[0] = op; pkt[1] = 8'h00; pkt[2] = cnt[15:8]; pkt[3] = cnt[7:0];
        pkt[4] = addr[31:24]; pkt[5] = addr[23:16]; pkt[6] = addr[15:8]; pkt[7] = addr[7:0];
    endtask

    task automatic send_pkt(input int n);
        for (int i = 0; i < n; i++) send_byte(pkt[i], i == 0, i == n - 1);
    endtask

    task automatic wait_done();
        int g = 0;
        while (!in_ready && g < 4000) begin @(negedge clk); g++; end
    endtask

    task automatic chk_rsp(input logic [7:0] op, input logic [15:0] cnt, input int base, input string req);
        check(rsn - base == 4, req, 32'(rsn - base), 4);
        check(rb[base] == op, req, rb[base], op);
        check(rb[base+1] == 8'h00, req, rb[base+1], 0);
        check({rb[base+2], rb[base+3]} == cnt, req, {rb[base+2], rb[base+3]}, cnt);
        check(rs[base] && re[base+3], req, {rs[base], re[base+3]}, 2'b11);
    endtask

    task automatic do_write(input logic [7:0] op, input int nw, input logic [31:0] addr,
                            input int t, input int extra, input string req);
        int w0 = wn, b0 = rsn, r0 = rn;
        set_hdr(op, 16'(nw * 4), addr);
        for (int k = 0; k < nw; k++)
            for (int j = 0; j < 4; j++) pkt[8 + 4*k + j] = wdat(t, k) >> (8*j);
        for (int x = 0; x < extra; x++) pkt[8 + 4*nw + x] = 8'h33 + 8'(x);
        send_pkt(8 + 4*nw + extra);
        check(!in_ready, "R11 busy after eop", in_ready, 0);
        wait_done();
        check(wn - w0 == nw && rn == r0, req, 32'(wn - w0), 32'(nw));
        for (int k = 0; k < nw; k++) begin
            check(wa[w0+k] == addr + 32'(4*k), req, wa[w0+k], addr + 32'(4*k));
            check(wd[w0+k] == wdat(t, k), req, wd[w0+k], wdat(t, k));
        end
        chk_rsp(op | 8'h80, 16'(nw * 4), b0, "R4 write response");
    endtask

    task automatic do_read(input logic [7:0] op, input int nw, input logic [31:0] addr,
                           input int extra, input string req);
        int r0 = rn, b0 = rsn;
        set_hdr(op, 16'(nw * 4), addr);
        for (int x = 0; x < extra; x++) pkt[8 + x] = 8'h7B + 8'(x);
        send_pkt(8 + extra);
        wait_done();
        check(rn - r0 == nw, req, 32'(rn - r0), 32'(nw));
        check(rsn - b0 == 4*nw, req, 32'(rsn - b0), 32'(4*nw));
        for (int k = 0; k < nw; k++) begin
            logic [31:0] w;
            w = pat(int'((addr >> 2) + 32'(k)) & 63);
            for (int j = 0; j < 4; j++) begin
                int p;
                p = b0 + 4*k + j;
                check(rb[p] == 8'(w >> (8*j)), req, rb[p], 8'(w >> (8*j)));
                check(rs[p] == (p == b0) && re[p] == (p == b0 + 4*nw - 1), req,
                      {rs[p], re[p]}, {p == b0, p == b0 + 4*nw - 1});
            end
        end
    endtask

    task automatic do_reject(input logic [7:0] op, input logic [15:0] cnt);
        int w0 = wn, r0 = rn, b0 = rsn;
        set_hdr(op, cnt, 32'h0000_0040);
        send_pkt(8);
        wait_done();
        check(wn == w0 && rn == r0, "R7 reject no bus", 32'(wn - w0 + rn - r0), 0);
        chk_rsp(op | 8'h80, 16'h0, b0, "R7 reject response");
    endtask

    task automatic expect_quiet(input int b0, input int w0, input int r0, input string req);
        repeat (30) @(negedge clk);
        check(rsn == b0 && wn == w0 && rn == r0, req, 32'(rsn - b0 + wn - w0 + rn - r0), 0);
        check(in_ready, req, in_ready, 1);
    endtask

    initial begin
        int b0, w0, r0;
        for (int i = 0; i < 64; i++) mem[i] = pat(i);
        repeat (4) @(negedge clk);
        check(in_ready == 1 && out_valid == 0, "R11 reset", {in_ready, out_valid}, 2'b10);
        check(!bus_write && !bus_read, "R8 reset", {bus_write, bus_read}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // single writes
        for (int a = 0; a < 4; a++) do_write(8'h00, 1, 32'h2000_0000 + 32'(a*12), a, 0, "R2 single write");
        // sequential writes, all lengths, stalled and not
        for (int nw = 1; nw <= MAXW; nw++)
            for (int s = 0; s < 2; s++) begin
                stall_bus = s[0];
                do_write(8'h04, nw, 32'h1000_0000 + 32'(4*(nw*5 + s)), nw*2 + s, 0, "R3 seq write");
            end
        stall_bus = 0;
        do_write(8'h04, 2, 32'h1000_0080, 9, 3, "R10 trailing bytes write");

        // reads
        for (int i = 0; i < 64; i++) mem[i] = pat(i);
        for (int a = 0; a < 3; a++) do_read(8'h10, 1, 32'h3000_0000 + 32'(a*20), 0, "R5 single read");
        for (int nw = 1; nw <= 6; nw++) begin
            stall_out = nw[0];
            stall_bus = nw[1];
            do_read(8'h14, nw, 32'h3000_0000 + 32'(nw*8), 0, "R6 seq read");
        end
        stall_out = 0; stall_bus = 0;
        do_read(8'h10, 1, 32'h0000_0010, 2, "R10 trailing bytes read");

        // rejects on bad counts and opcodes
        do_reject(8'h00, 16'd8);
        do_reject(8'h04, 16'(4*(MAXW+1)));
        do_reject(8'h04, 16'd6);
        do_reject(8'h10, 16'd8);
        do_reject(8'h14, 16'd0);
        do_reject(8'h14, 16'd2);
        do_reject(8'h7F, 16'd4);
        for (int op = 0; op < 256; op++)
            if (!(op == 8'h00 || op == 8'h04 || op == 8'h10 || op == 8'h14))
                do_reject(8'(op), 16'd4);

        // truncated packets
        b0 = rsn; w0 = wn; r0 = rn;
        set_hdr(8'h10, 16'd4, 32'h20);
        for (int i = 0; i < 4; i++) send_byte(pkt[i], i == 0, i == 3);
        expect_quiet(b0, w0, r0, "R9 short header");
        set_hdr(8'h04, 16'd8, 32'h20);
        for (int i = 8; i < 12; i++) pkt[i] = 8'(i);
        for (int i = 0; i < 12; i++) send_byte(pkt[i], i == 0, i == 11);
        expect_quiet(b0, w0, r0, "R9 short write data");
        set_hdr(8'h00, 16'd4, 32'h20);
        send_pkt(8);
        expect_quiet(b0, w0, r0, "R9 write without data");
        send_byte(8'h10, 1, 1);
        expect_quiet(b0, w0, r0, "R9 one-byte packet");

        // junk before start, then a read
        send_byte(8'h10, 0, 0);
        send_byte(8'h14, 0, 1);
        expect_quiet(b0, w0, r0, "R1 junk ignored");
        do_read(8'h10, 1, 32'h0000_0024, 0, "R1 read after junk");

        // restart mid header
        w0 = wn;
        send_byte(8'h04, 1, 0);
        send_byte(8'h00, 0, 0);
        send_byte(8'h00, 0, 0);
        do_read(8'h14, 2, 32'h0000_0030, 0, "R10 restart read");
        check(wn == w0, "R10 restart no write", 32'(wn - w0), 0);

        check(hold_viol == 0, "R8 command hold", 32'(hold_viol), 0);
        check(both_viol == 0, "R8 read/write exclusive", 32'(both_viol), 0);
        check(stall_viol == 0, "R11 output hold", 32'(stall_viol), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule